// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block sits between an in-order stream of memory requests and the command bus of a multi-bank DRAM device. Each request names a bank, a row and a column and asks for one burst read or write. The scheduler keeps each bank's row open after use, which is an open-page policy. It turns every request into the shortest legal command sequence. A request to the row that is already open needs only a column command. A request to a closed bank needs an activate followed by the column command. A request to a different row in an open bank needs a precharge, then an activate, then the column command.

Every command is delayed until the spacing rules between commands are met. These rules cover activate to column access, column access to column access, activate to activate within a bank and across banks, and precharge to activate. Three counters report the total number of activations, page hits and page misses. They let a caller measure how much a strided access pattern costs compared with a sequential one.

Top module: `dram_cmd_sched`

## Requirements
- R1: After a synchronous reset the command bus is idle (cmd_valid low), all three counters read zero, and every bank is closed, so the first request to any bank starts with an activate.
- R2: A request to a closed bank produces an ACT (cmd_op=1, row on cmd_row) and then its column command. The column command is issued exactly T_RCD cycles after the ACT when nothing else blocks it, and never sooner.
- R3: A request whose row is open in its bank produces only its column command, with no ACT or PRE, and increments hit_count by one.
- R4: A request to another row in an open bank produces PRE (cmd_op=2), then ACT, then the column command. The ACT comes at least T_RP cycles after the PRE, exactly T_RP when no other rule binds. Any request that was not a hit increments miss_count by one.
- R5: Two column commands to the same bank are at least T_CCD cycles apart, exactly T_CCD when requests arrive back to back.
- R6: Two ACTs to the same bank are at least T_RC cycles apart, exactly T_RC when the bank is reopened straight away.
- R7: Two ACTs to different banks are at least T_RRD cycles apart, exactly T_RRD when that rule is the one that binds.
- R8: Requests are served strictly in order, with at most one command per cycle. Each command carries the request's bank. A read issues cmd_op=3 and a write issues cmd_op=4, each with the column on cmd_col, and each moves a burst of BURST_LEN transfers.
- R9: act_count increments by exactly one for each ACT issued on the command bus, so it tracks the activate count.
- R10: req_ready is high only in the cycle where the request's column command is decided. While any rule blocks the request, req_ready stays low and the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Burst start column |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | 1 ACT, 2 PRE, 3 RD, 4 WR |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row address (ACT only, else 0) |
| cmd_col | output | COL_W | Column address (RD/WR only, else 0) |
| act_count | output | CNT_W | Total activations |
| hit_count | output | CNT_W | Requests that found their row open |
| miss_count | output | CNT_W | Requests that needed an activate |

## Verification
On every cycle, the assertions check the spacing rules as seen on the command bus: activate to column, column to column, activate to activate within a bank and across banks, and precharge to activate. They also tie the activate counter to the issued activates and check that acceptance needs a valid request. Only the bench scenarios can show that the greedy scheduler issues each command at the earliest legal cycle rather than merely a legal one. The same holds for the choice of command sequence for hits, misses and closed banks, and for the counters telling a strided pattern apart from a sequential one.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_PRE = 3'd2,
      OP_RD  = 3'd3,
      OP_WR  = 3'd4
   } cmd_op_e;

   function automatic int tmr_width(input int span);
      return (span > 1) ? $clog2(span) : 1;
   endfunction
endpackage

// File: rtl/dcs_countdown.sv
// Spacing timer: after start in cycle t, expired is high again from cycle t+SPAN.
module dcs_countdown #(
   parameter int SPAN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic expired
);
   localparam int W = dcs_pkg::tmr_width(SPAN);
   localparam logic [W-1:0] RELOAD = W'(SPAN - 1);

   logic [W-1:0] cnt_q;

   generate
      if (SPAN < 1) begin : g_bad_span
         $fatal(1, "dcs_countdown: SPAN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start)
         cnt_q <= RELOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/dcs_bank.sv
// Per-bank state: open flag, open row and the bank-local spacing timers.
module dcs_bank #(
   parameter int ROW_W = 14,
   parameter int T_RCD = 12,
   parameter int T_CCD = 4,
   parameter int T_RC  = 32,
   parameter int T_RP  = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_fire,
   input  logic             pre_fire,
   input  logic             col_fire,
   input  logic [ROW_W-1:0] act_row,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             col_ok,
   output logic             act_ok
);
   logic rcd_done, ccd_done, rc_done, rp_done;

   dcs_countdown #(.SPAN(T_RCD)) u_rcd (.clk(clk), .rst(rst), .start(act_fire), .expired(rcd_done));
   dcs_countdown #(.SPAN(T_CCD)) u_ccd (.clk(clk), .rst(rst), .start(col_fire), .expired(ccd_done));
   dcs_countdown #(.SPAN(T_RC))  u_rc  (.clk(clk), .rst(rst), .start(act_fire), .expired(rc_done));
   dcs_countdown #(.SPAN(T_RP))  u_rp  (.clk(clk), .rst(rst), .start(pre_fire), .expired(rp_done));

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open  <= 1'b0;
         open_row <= '0;
      end else if (act_fire) begin
         is_open  <= 1'b1;
         open_row <= act_row;
      end else if (pre_fire) begin
         is_open  <= 1'b0;
      end
   end

   assign col_ok = rcd_done && ccd_done;
   assign act_ok = rc_done && rp_done;
endmodule

// File: rtl/dcs_stats.sv
// Free-running activation / hit / miss counters (wrap on overflow).
module dcs_stats #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_inc,
   input  logic             hit_inc,
   input  logic             miss_inc,
   output logic [CNT_W-1:0] act_count,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   localparam int NCNT = 3;

   logic [NCNT-1:0] inc;
   logic [CNT_W-1:0] cnt_q [NCNT];

   assign inc = {miss_inc, hit_inc, act_inc};

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_cnt
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q[i] <= '0;
            else if (inc[i])
               cnt_q[i] <= cnt_q[i] + 1'b1;
         end
      end
   endgenerate

   assign act_count  = cnt_q[0];
   assign hit_count  = cnt_q[1];
   assign miss_count = cnt_q[2];
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched #(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   parameter int COL_W     = 10,
   parameter int CNT_W     = 32,
   parameter int BURST_LEN = 8,
   parameter int T_RCD     = 12,
   parameter int T_CCD     = 4,
   parameter int T_RC      = 32,
   parameter int T_RRD     = 7,
   parameter int T_RP      = 12,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [CNT_W-1:0]  act_count,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   import dcs_pkg::*;

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $fatal(1, "dram_cmd_sched: NUM_BANKS must be a power of two >= 2");
      end
      if (T_CCD < BURST_LEN / 2) begin : g_bad_ccd
         $fatal(1, "dram_cmd_sched: T_CCD shorter than one burst on the data bus");
      end
      if (T_RC < T_RCD) begin : g_bad_rc
         $fatal(1, "dram_cmd_sched: T_RC must cover T_RCD");
      end
   endgenerate

   // bank state
   logic [NUM_BANKS-1:0] bk_open, bk_col_ok, bk_act_ok;
   logic [NUM_BANKS-1:0] act_fire, pre_fire, col_fire;
   logic [ROW_W-1:0]     bk_row [NUM_BANKS];
   logic                 rrd_ok;

   // decision
   cmd_op_e dec_op;
   logic    head_open, head_hit;
   logic    head_missed_q;

   assign head_open = bk_open[req_bank];
   assign head_hit  = head_open && (bk_row[req_bank] == req_row);

   always_comb begin
      dec_op = OP_NOP;
      if (req_valid) begin
         if (head_hit) begin
            if (bk_col_ok[req_bank])
               dec_op = req_write ? OP_WR : OP_RD;
         end else if (head_open) begin
            dec_op = OP_PRE;
         end else if (bk_act_ok[req_bank] && rrd_ok) begin
            dec_op = OP_ACT;
         end
      end
   end

   assign req_ready = (dec_op == OP_RD) || (dec_op == OP_WR);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         assign sel         = (req_bank == BANK_W'(b));
         assign act_fire[b] = sel && (dec_op == OP_ACT);
         assign pre_fire[b] = sel && (dec_op == OP_PRE);
         assign col_fire[b] = sel && req_ready;

         dcs_bank #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_CCD(T_CCD), .T_RC(T_RC), .T_RP(T_RP)
         ) u_bank (
            .clk(clk), .rst(rst),
            .act_fire(act_fire[b]), .pre_fire(pre_fire[b]), .col_fire(col_fire[b]),
            .act_row(req_row),
            .is_open(bk_open[b]), .open_row(bk_row[b]),
            .col_ok(bk_col_ok[b]), .act_ok(bk_act_ok[b])
         );
      end
   endgenerate

   dcs_countdown #(.SPAN(T_RRD)) u_rrd (
      .clk(clk), .rst(rst), .start(dec_op == OP_ACT), .expired(rrd_ok)
   );

   // a request that needed an activate is a miss when its column command goes out
   always_ff @(posedge clk) begin
      if (rst)
         head_missed_q <= 1'b0;
      else if (req_ready)
         head_missed_q <= 1'b0;
      else if (dec_op == OP_ACT)
         head_missed_q <= 1'b1;
   end

   dcs_stats #(.CNT_W(CNT_W)) u_stats (
      .clk(clk), .rst(rst),
      .act_inc(dec_op == OP_ACT),
      .hit_inc(req_ready && !head_missed_q),
      .miss_inc(req_ready && head_missed_q),
      .act_count(act_count), .hit_count(hit_count), .miss_count(miss_count)
   );

   // registered command bus
   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_valid <= 1'b0;
         cmd_op    <= OP_NOP;
         cmd_bank  <= '0;
         cmd_row   <= '0;
         cmd_col   <= '0;
      end else begin
         cmd_valid <= (dec_op != OP_NOP);
         cmd_op    <= dec_op;
         cmd_bank  <= (dec_op != OP_NOP) ? req_bank : '0;
         cmd_row   <= (dec_op == OP_ACT) ? req_row : '0;
         cmd_col   <= req_ready ? req_col : '0;
      end
   end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
   parameter int NUM_BANKS = 8,
   parameter int CNT_W     = 32,
   parameter int T_RCD     = 12,
   parameter int T_CCD     = 4,
   parameter int T_RC      = 32,
   parameter int T_RRD     = 7,
   parameter int T_RP      = 12,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [BANK_W-1:0] cmd_bank,
   input logic [CNT_W-1:0]  act_count
);
   localparam int SW = $clog2(T_RCD + T_CCD + T_RC + T_RRD + T_RP + 4);
   localparam logic [SW-1:0] SAT = '1;

   logic is_act, is_pre, is_col;
   assign is_act = cmd_valid && (cmd_op == 3'd1);
   assign is_pre = cmd_valid && (cmd_op == 3'd2);
   assign is_col = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);

   logic [SW-1:0] s_act [NUM_BANKS];
   logic [SW-1:0] s_col [NUM_BANKS];
   logic [SW-1:0] s_pre [NUM_BANKS];
   logic [NUM_BANKS-1:0] seen_act, seen_col, seen_pre;
   logic [SW-1:0] s_any_act;
   logic          seen_any_act;

   function automatic logic [SW-1:0] bump(input logic [SW-1:0] v);
      return (v == SAT) ? v : v + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_act <= '0; seen_col <= '0; seen_pre <= '0; seen_any_act <= 1'b0;
         s_any_act <= '0;
         for (int b = 0; b < NUM_BANKS; b++) begin
            s_act[b] <= '0; s_col[b] <= '0; s_pre[b] <= '0;
         end
      end else begin
         s_any_act <= is_act ? SW'(1) : bump(s_any_act);
         if (is_act) seen_any_act <= 1'b1;
         for (int b = 0; b < NUM_BANKS; b++) begin
            logic here;
            here = (cmd_bank == BANK_W'(b));
            s_act[b] <= (is_act && here) ? SW'(1) : bump(s_act[b]);
            s_col[b] <= (is_col && here) ? SW'(1) : bump(s_col[b]);
            s_pre[b] <= (is_pre && here) ? SW'(1) : bump(s_pre[b]);
            if (is_act && here) seen_act[b] <= 1'b1;
            if (is_col && here) seen_col[b] <= 1'b1;
            if (is_pre && here) seen_pre[b] <= 1'b1;
         end
      end
   end

   a_r2_act_to_col: assert property (@(posedge clk) disable iff (rst)
      is_col |-> (seen_act[cmd_bank] && s_act[cmd_bank] >= SW'(T_RCD)));
   a_r5_col_to_col: assert property (@(posedge clk) disable iff (rst)
      is_col |-> (!seen_col[cmd_bank] || s_col[cmd_bank] >= SW'(T_CCD)));
   a_r6_act_to_act_bank: assert property (@(posedge clk) disable iff (rst)
      is_act |-> (!seen_act[cmd_bank] || s_act[cmd_bank] >= SW'(T_RC)));
   a_r7_act_to_act_any: assert property (@(posedge clk) disable iff (rst)
      is_act |-> (!seen_any_act || s_any_act >= SW'(T_RRD)));
   a_r4_pre_to_act: assert property (@(posedge clk) disable iff (rst)
      is_act |-> (!seen_pre[cmd_bank] || s_pre[cmd_bank] >= SW'(T_RP)));
   a_r9_act_counted: assert property (@(posedge clk) disable iff (rst)
      (act_count != $past(act_count)) == is_act);
   a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> req_valid);
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !cmd_valid);
   a_r8_legal_op: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> (cmd_op >= 3'd1 && cmd_op <= 3'd4));
endmodule

bind dram_cmd_sched dcs_checker #(
   .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W),
   .T_RCD(T_RCD), .T_CCD(T_CCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP)
) u_dcs_checker (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .act_count(act_count)
);

// File: tb/tb_dram_cmd_sched.sv
`timescale 1ns/1ps
module tb_dram_cmd_sched;
   localparam int NB = 8, RW = 14, CW = 10, NW = 32, BW = 3;
   localparam int TRCD = 3, TCCD = 4, TRC = 12, TRRD = 6, TRP = 3;

   logic clk = 1'b0, rst = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0, req_ready;
   logic [BW-1:0] req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic cmd_valid;
   logic [2:0] cmd_op;
   logic [BW-1:0] cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_col;
   logic [NW-1:0] act_count, hit_count, miss_count;

   always #4 clk = ~clk;

   dram_cmd_sched #(
      .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .CNT_W(NW), .BURST_LEN(8),
      .T_RCD(TRCD), .T_CCD(TCCD), .T_RC(TRC), .T_RRD(TRRD), .T_RP(TRP)
   ) dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_row(cmd_row), .cmd_col(cmd_col),
      .act_count(act_count), .hit_count(hit_count), .miss_count(miss_count)
   );

   typedef struct { int op; int bank; int row; int col; } exp_t;
   exp_t exp_q[$];

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   int m_open[NB], m_row[NB];
   int m_act = 0, m_hit = 0, m_miss = 0;
   int t_act[NB], t_col[NB], t_pre[NB], t_any_act;
   int g_rcd, g_ccd, g_rc, g_rp, g_rrd;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected commands and records measured gaps
   always @(negedge clk) begin
      if (!rst && cmd_valid) begin
         if (exp_q.size() == 0) begin
            check("R8", "unexpected command op", int'(cmd_op), 0);
         end else begin
            exp_t e;
            int b;
            e = exp_q.pop_front();
            b = int'(cmd_bank);
            check("R8", "command op", int'(cmd_op), e.op);
            check("R8", "command bank", b, e.bank);
            check("R8", "command row", int'(cmd_row), e.row);
            check("R8", "command col", int'(cmd_col), e.col);
            if (cmd_op == 3'd1) begin
               g_rc = cyc - t_act[b]; g_rp = cyc - t_pre[b]; g_rrd = cyc - t_any_act;
               t_act[b] = cyc; t_any_act = cyc;
            end else if (cmd_op == 3'd2) begin
               t_pre[b] = cyc;
            end else begin
               g_rcd = cyc - t_act[b]; g_ccd = cyc - t_col[b];
               t_col[b] = cyc;
            end
         end
      end
   end

   // driver: model the expected command sequence, then hand the request over
   task automatic send(input bit wr, input int bank, input int row, input int col,
                       output int first_ready);
      exp_t e;
      e.bank = bank;
      if (m_open[bank] && m_row[bank] == row) begin
         m_hit++;
      end else begin
         if (m_open[bank]) begin
            e.op = 2; e.row = 0; e.col = 0; exp_q.push_back(e);
         end
         e.op = 1; e.row = row; e.col = 0; exp_q.push_back(e);
         m_act++; m_miss++;
         m_open[bank] = 1; m_row[bank] = row;
      end
      e.op = wr ? 4 : 3; e.row = 0; e.col = col; exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_bank = BW'(bank);
      req_row = RW'(row); req_col = CW'(col);
      #1 first_ready = int'(req_ready);
      while (!req_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk); #2;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   initial begin
      int fr, a0, hit0, miss0;
      for (int b = 0; b < NB; b++) begin
         m_open[b] = 0; m_row[b] = 0; t_act[b] = -1000; t_col[b] = -1000; t_pre[b] = -1000;
      end
      t_any_act = -1000;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      settle();
      // R1: reset state
      check("R1", "cmd_valid after reset", int'(cmd_valid), 0);
      check("R1", "act_count after reset", int'(act_count), 0);
      check("R1", "hit+miss after reset", int'(hit_count + miss_count), 0);

      // R2 / R10: closed bank, ACT then read exactly TRCD later
      send(1'b0, 0, 5, 8, fr);
      check("R10", "ready on first cycle of blocked request", fr, 0);
      settle();
      check("R2", "ACT to column gap", g_rcd, TRCD);
      check("R4", "miss count after closed bank", int'(miss_count), 1);

      // R3 / R5: open-row hit, back to back column spacing
      send(1'b1, 0, 5, 16, fr);
      settle();
      check("R5", "column to column gap", g_ccd, TCCD);
      check("R3", "hit count", int'(hit_count), 1);

      // R6: immediate reopen of bank 0 is bound by TRC
      send(1'b0, 0, 9, 24, fr);
      settle();
      check("R6", "same-bank ACT to ACT gap", g_rc, TRC);

      // R4: after idle, precharge-to-activate spacing binds
      idle(20);
      send(1'b0, 0, 2, 32, fr);
      settle();
      check("R4", "PRE to ACT gap", g_rp, TRP);

      // R7: activates to two fresh banks bound by TRRD
      idle(20);
      send(1'b0, 1, 1, 0, fr);
      send(1'b1, 2, 7, 40, fr);
      settle();
      check("R7", "cross-bank ACT to ACT gap", g_rrd, TRRD);

      // R9 / R3 / R4: strided versus sequential cost
      a0 = int'(act_count); hit0 = int'(hit_count); miss0 = int'(miss_count);
      for (int i = 0; i < 8; i++) send(1'b0, 3, 100 + i, 8 * i, fr);
      settle();
      check("R9", "strided activations", int'(act_count) - a0, 8);
      check("R4", "strided misses", int'(miss_count) - miss0, 8);
      a0 = int'(act_count); hit0 = int'(hit_count);
      for (int i = 0; i < 8; i++) send(i[0], 4, 55, 8 * i, fr);
      settle();
      check("R9", "sequential activations", int'(act_count) - a0, 1);
      check("R3", "sequential hits", int'(hit_count) - hit0, 7);

      // mixed pattern across banks
      for (int i = 0; i < 12; i++) send(i[1], i % 3 + 5, (i / 4) * 3, i * 8, fr);
      idle(4);
      check("R8", "all expected commands issued", exp_q.size(), 0);
      check("R9", "total activations", int'(act_count), m_act);
      check("R3", "total hits", int'(hit_count), m_hit);
      check("R4", "total misses", int'(miss_count), m_miss);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule